// File: doc/BRIEF.md
# Segment Access Permission Checker

This block decides whether one memory access made through a cached segment descriptor may proceed. Each request carries the access kind (read, write or instruction fetch), a 32-bit offset, the access length as length minus one (so lengths 1 to 16), and the cached descriptor fields: a valid flag, a present flag, a 4-bit type, the byte-scaled limit and the default-size bit. It also carries a flag for 64-bit mode, a flag that marks the stack segment, and the descriptor's current fast-path permission bits.

The decision is computed combinationally and registered. One cycle after a request the block returns an allow flag, a fault code, and the merged fast-path permission bits. The surrounding pipeline writes these bits back into the descriptor cache so that later accesses can skip the full check. Normal (expand-up) segments are checked against a ceiling. Expand-down segments are checked against a floor, and their ceiling depends on the default-size bit.

Top module: `seg_access_checker`

## Requirements
- R1: When `long_mode` is 1, every request is allowed whatever the descriptor holds, and `perm_out` becomes 4'b1111.
- R2: Outside 64-bit mode, a request faults when `dsc_valid` or `dsc_present` is 0. On a fault `perm_out` equals `perm_in` unchanged.
- R3: Kind encoding is 0 = read, 1 = write, 2 = execute. A write is permitted only for types 2, 3, 6 and 7. Every other type faults on a write.
- R4: A read is permitted for types 0 to 7, 10, 11, 14 and 15. It faults for types 8, 9, 12 and 13. Kind code 3 is reserved and always faults outside 64-bit mode.
- R5: An execute request is permitted for all 16 types. Execute-only types (8, 9, 12, 13) get the upward limit check and never add fast-path bits.
- R6: A segment is expand-down when type bit 3 is 0 and bit 2 is 1. For any other type the access faults if length-1 > limit or if offset > limit-(length-1). The arithmetic does not wrap.
- R7: For an expand-down segment the ceiling is 0xFFFFFFFF when `dsc_big` is 1 and 0x0000FFFF when it is 0. The access faults if offset <= limit, if offset > ceiling, or if ceiling-offset < length-1.
- R8: Bit positions in `perm_out` are [0] read, [1] write, [2] read over the full 4 GiB, [3] write over the full 4 GiB. An allowed access to a non-expand-down, non-execute-only segment with limit >= 7 adds bit 0, and adds bit 1 if it is a write. If the limit is also 0xFFFFFFFF, it adds bit 2, and adds bit 3 if it is a write.
- R9: Expand-down segments never add fast-path bits. Bits already set in `perm_in` are always kept in `perm_out`.
- R10: `rsp_fault` is 0 on an allowed access. On a fault it is 2 when `seg_is_stack` is 1 and 1 otherwise.
- R11: After reset `rsp_vld`, `rsp_ok`, `rsp_fault` and `perm_out` are 0. The result of a request sampled at a clock edge appears after that edge with `rsp_vld` = 1. Back-to-back requests give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_ofs | input | 32 | Offset within the segment |
| acc_len_m1 | input | 4 | Access length minus one |
| seg_is_stack | input | 1 | Request goes through the stack segment |
| long_mode | input | 1 | Processor is in 64-bit mode |
| dsc_valid | input | 1 | Descriptor cache entry valid |
| dsc_present | input | 1 | Descriptor present flag |
| dsc_type | input | 4 | Descriptor type |
| dsc_limit | input | 32 | Byte-scaled segment limit |
| dsc_big | input | 1 | Default-size bit (selects the expand-down ceiling) |
| perm_in | input | 4 | Current fast-path permission bits |
| rsp_vld | output | 1 | Result valid |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 stack fault |
| perm_out | output | 4 | Merged fast-path permission bits |

## Verification
Two things resolve in the same response: the fault-code choice and the merge of the fast-path bits. A faulting access must report the right code and still return every bit it was given.

The bench provokes this in three ways. It sends faulting requests with nonzero `perm_in`, both with and without the stack flag. It sends passing requests through the stack segment, which must report no fault code yet still merge new bits. It sends requests back to back, so that one result must not leak into the next.

Each response is judged on all three fields together.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int PERM_W  = 4;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_R4 = 2;
    localparam int PERM_W4 = 3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_GP    = 2'd1,
        FLT_SS    = 2'd2,
        FLT_UNUSD = 2'd3
    } flt_code_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        logic exp_dn;
        logic x_only;
    } seg_class_t;

    // Per-type attributes; the whole type field is decoded.
    function automatic seg_class_t classify(input logic [3:0] t);
        seg_class_t c;
        c = '0;
        case (t)
            4'd0, 4'd1:               c.rd_ok = 1'b1;
            4'd2, 4'd3:               begin c.rd_ok = 1'b1; c.wr_ok = 1'b1; end
            4'd4, 4'd5:               begin c.rd_ok = 1'b1; c.exp_dn = 1'b1; end
            4'd6, 4'd7:               begin c.rd_ok = 1'b1; c.wr_ok = 1'b1; c.exp_dn = 1'b1; end
            4'd8, 4'd9, 4'd12, 4'd13: c.x_only = 1'b1;
            default:                  c.rd_ok = 1'b1;
        endcase
        return c;
    endfunction

    function automatic logic kind_permits(input acc_kind_e k, input seg_class_t c);
        case (k)
            ACC_READ:  return c.rd_ok;
            ACC_WRITE: return c.wr_ok;
            ACC_EXEC:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
    parameter int OFS_W   = 32,
    parameter int LEN_W   = 4,
    parameter int SMALL_W = 16
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [OFS_W-1:0] limit,
    input  logic             big,
    output logic             up_pass,
    output logic             dn_pass
);
    localparam int EXT_W = OFS_W + 1;

    logic [EXT_W-1:0] len_x;
    logic [EXT_W-1:0] lim_x;
    logic [EXT_W-1:0] ofs_x;
    logic [EXT_W-1:0] ceil_up;
    logic [OFS_W-1:0] ceil_dn;
    logic [OFS_W-1:0] room_dn;

    always_comb begin
        len_x   = {{(EXT_W-LEN_W){1'b0}}, len_m1};
        lim_x   = {1'b0, limit};
        ofs_x   = {1'b0, ofs};
        // Wide intermediate: only used when len_m1 <= limit, so no wrap.
        ceil_up = lim_x - len_x;
        up_pass = (len_x <= lim_x) && (ofs_x <= ceil_up);

        ceil_dn = big ? {OFS_W{1'b1}}
                      : {{(OFS_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
        room_dn = ceil_dn - ofs;
        dn_pass = (ofs > limit) && (ofs <= ceil_dn)
               && ({1'b0, room_dn} >= len_x);
    end
endmodule

// File: rtl/seg_fast_grant.sv
module seg_fast_grant
    import seg_chk_pkg::*;
#(
    parameter int OFS_W    = 32,
    parameter int FAST_MIN = 7
) (
    input  logic              long_mode,
    input  logic              allowed,
    input  acc_kind_e         kind,
    input  logic              exp_dn,
    input  logic              x_only,
    input  logic [OFS_W-1:0]  limit,
    output logic [PERM_W-1:0] grant
);
    logic lim_wide;
    logic lim_full;
    logic is_wr;

    always_comb begin
        lim_wide = (limit >= OFS_W'(FAST_MIN));
        lim_full = &limit;
        is_wr    = (kind == ACC_WRITE);
        grant    = '0;
        if (long_mode) begin
            grant = '1;
        end else if (allowed && !exp_dn && !x_only && lim_wide) begin
            grant[PERM_RD] = 1'b1;
            grant[PERM_WR] = is_wr;
            grant[PERM_R4] = lim_full;
            grant[PERM_W4] = lim_full && is_wr;
        end
    end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int OFS_W    = 32,
    parameter int LEN_W    = 4,
    parameter int SMALL_W  = 16,
    parameter int FAST_MIN = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_vld,
    input  logic [1:0]       acc_kind,
    input  logic [OFS_W-1:0] acc_ofs,
    input  logic [LEN_W-1:0] acc_len_m1,
    input  logic             seg_is_stack,
    input  logic             long_mode,
    input  logic             dsc_valid,
    input  logic             dsc_present,
    input  logic [3:0]       dsc_type,
    input  logic [OFS_W-1:0] dsc_limit,
    input  logic             dsc_big,
    input  logic [3:0]       perm_in,
    output logic             rsp_vld,
    output logic             rsp_ok,
    output logic [1:0]       rsp_fault,
    output logic [3:0]       perm_out
);
    seg_class_t        cls;
    acc_kind_e         kind;
    logic              up_pass;
    logic              dn_pass;
    logic              allow;
    logic [PERM_W-1:0] grant;
    flt_code_e         flt;

    seg_limit_unit #(
        .OFS_W   (OFS_W),
        .LEN_W   (LEN_W),
        .SMALL_W (SMALL_W)
    ) u_limit (
        .ofs     (acc_ofs),
        .len_m1  (acc_len_m1),
        .limit   (dsc_limit),
        .big     (dsc_big),
        .up_pass (up_pass),
        .dn_pass (dn_pass)
    );

    always_comb begin
        kind  = acc_kind_e'(acc_kind);
        cls   = classify(dsc_type);
        allow = long_mode
             || (dsc_valid && dsc_present && kind_permits(kind, cls)
                 && (cls.exp_dn ? dn_pass : up_pass));
        if (allow)
            flt = FLT_NONE;
        else
            flt = seg_is_stack ? FLT_SS : FLT_GP;
    end

    seg_fast_grant #(
        .OFS_W    (OFS_W),
        .FAST_MIN (FAST_MIN)
    ) u_grant (
        .long_mode (long_mode),
        .allowed   (allow),
        .kind      (kind),
        .exp_dn    (cls.exp_dn),
        .x_only    (cls.x_only),
        .limit     (dsc_limit),
        .grant     (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld   <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_fault <= FLT_NONE;
            perm_out  <= '0;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
                rsp_ok    <= allow;
                rsp_fault <= flt;
                perm_out  <= perm_in | grant;
            end
        end
    end

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld);

    // R1
    long_mode_open_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && long_mode) |=> (rsp_ok && perm_out == 4'hF));

    // R2
    bad_desc_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !long_mode && !(dsc_valid && dsc_present)) |=> !rsp_ok);

    // R3
    code_write_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !long_mode && acc_kind == 2'd1 && dsc_type[3]) |=> !rsp_ok);

    // R9
    perm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> ((perm_out & $past(perm_in)) == $past(perm_in)));

    // R10
    fault_code_match_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> (rsp_ok == (rsp_fault == 2'd0)));

    // R2
    fault_keeps_perm_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && !rsp_ok) |-> (perm_out == $past(perm_in)));
endmodule

// File: tb/seg_access_checker_tb_top.sv
module seg_access_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [31:0] acc_ofs = '0;
    logic [3:0]  acc_len_m1 = '0;
    logic        seg_is_stack = 1'b0;
    logic        long_mode = 1'b0;
    logic        dsc_valid = 1'b1;
    logic        dsc_present = 1'b1;
    logic [3:0]  dsc_type = '0;
    logic [31:0] dsc_limit = '0;
    logic        dsc_big = 1'b0;
    logic [3:0]  perm_in = '0;
    logic        rsp_vld;
    logic        rsp_ok;
    logic [1:0]  rsp_fault;
    logic [3:0]  perm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    seg_access_checker dut_i (
        .clk(clk), .rst(rst), .req_vld(req_vld), .acc_kind(acc_kind),
        .acc_ofs(acc_ofs), .acc_len_m1(acc_len_m1), .seg_is_stack(seg_is_stack),
        .long_mode(long_mode), .dsc_valid(dsc_valid), .dsc_present(dsc_present),
        .dsc_type(dsc_type), .dsc_limit(dsc_limit), .dsc_big(dsc_big),
        .perm_in(perm_in), .rsp_vld(rsp_vld), .rsp_ok(rsp_ok),
        .rsp_fault(rsp_fault), .perm_out(perm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives one request, waits one edge, checks the response.
    task automatic access(input string tag, input logic [1:0] k, input logic [3:0] t,
                          input logic [31:0] lim, input logic [31:0] ofs,
                          input logic [3:0] lm1, input logic big,
                          input logic [3:0] pin, input logic exp_ok,
                          input logic [3:0] exp_perm);
        acc_kind = k; dsc_type = t; dsc_limit = lim; acc_ofs = ofs;
        acc_len_m1 = lm1; dsc_big = big; perm_in = pin; req_vld = 1'b1;
        @(posedge clk); #1;
        chk({tag, " vld"}, 32'(rsp_vld), 32'd1);
        chk({tag, " ok"}, 32'(rsp_ok), 32'(exp_ok));
        chk({tag, " fault"}, 32'(rsp_fault),
            exp_ok ? 32'd0 : (seg_is_stack ? 32'd2 : 32'd1));
        chk({tag, " perm"}, 32'(perm_out), 32'(exp_perm));
    endtask

    task automatic idle();
        req_vld = 1'b0;
        @(posedge clk); #1;
        chk("R11 idle vld", 32'(rsp_vld), 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 reset vld", 32'(rsp_vld), 32'd0);
        chk("R11 reset ok", 32'(rsp_ok), 32'd0);
        chk("R11 reset fault", 32'(rsp_fault), 32'd0);
        chk("R11 reset perm", 32'(perm_out), 32'd0);
    endtask

    task automatic t_long();
        long_mode = 1'b1; dsc_valid = 1'b0;
        access("R1 long write code", 2'd1, 4'd8, 32'd0, 32'hFFFF_FFFF, 4'd15, 1'b0, 4'h0, 1'b1, 4'hF);
        long_mode = 1'b0; dsc_valid = 1'b1;
        idle();
    endtask

    task automatic t_desc();
        dsc_valid = 1'b0;
        access("R2 invalid", 2'd0, 4'd2, 32'hFF, 32'd0, 4'd0, 1'b0, 4'h1, 1'b0, 4'h1);
        dsc_valid = 1'b1; dsc_present = 1'b0;
        access("R2 not present", 2'd2, 4'd10, 32'hFF, 32'd0, 4'd0, 1'b0, 4'h5, 1'b0, 4'h5);
        dsc_present = 1'b1;
        idle();
    endtask

    task automatic t_write();
        access("R3 write rw", 2'd1, 4'd2, 32'hFF, 32'd0, 4'd0, 1'b0, 4'h0, 1'b1, 4'h3);
        access("R3 write ro", 2'd1, 4'd0, 32'hFF, 32'd0, 4'd0, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R3 write code", 2'd1, 4'd10, 32'hFF, 32'd0, 4'd0, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R3 write ro-dn", 2'd1, 4'd5, 32'hFFF, 32'h1000, 4'd3, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R3 write rw-dn", 2'd1, 4'd6, 32'hFFF, 32'h1000, 4'd3, 1'b0, 4'h0, 1'b1, 4'h0);
        idle();
    endtask

    task automatic t_read();
        access("R4 read xonly", 2'd0, 4'd9, 32'hFF, 32'd0, 4'd0, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R4 read xonly conf", 2'd0, 4'd13, 32'hFF, 32'd0, 4'd0, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R4 read code-rd", 2'd0, 4'd10, 32'h100, 32'h10, 4'd3, 1'b0, 4'h0, 1'b1, 4'h1);
        access("R4 read conf-rd", 2'd0, 4'd15, 32'h100, 32'h10, 4'd3, 1'b0, 4'h0, 1'b1, 4'h1);
        access("R4 reserved kind", 2'd3, 4'd2, 32'h100, 32'h0, 4'd0, 1'b0, 4'h0, 1'b0, 4'h0);
        idle();
    endtask

    task automatic t_exec();
        access("R5 exec xonly edge", 2'd2, 4'd8, 32'h100, 32'hFD, 4'd3, 1'b0, 4'h0, 1'b1, 4'h0);
        access("R5 exec xonly over", 2'd2, 4'd8, 32'h100, 32'hFE, 4'd3, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R5 exec data", 2'd2, 4'd2, 32'h100, 32'h0, 4'd0, 1'b0, 4'h0, 1'b1, 4'h1);
        access("R5 exec data-dn", 2'd2, 4'd4, 32'hFF, 32'h100, 4'd0, 1'b0, 4'h0, 1'b1, 4'h0);
        idle();
    endtask

    task automatic t_up();
        access("R6 small limit fit", 2'd0, 4'd0, 32'd3, 32'd0, 4'd3, 1'b0, 4'h0, 1'b1, 4'h0);
        access("R6 len over limit", 2'd0, 4'd0, 32'd3, 32'd0, 4'd4, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R6 top edge", 2'd0, 4'd0, 32'h10, 32'hD, 4'd3, 1'b0, 4'h0, 1'b1, 4'h1);
        access("R6 top over", 2'd0, 4'd0, 32'h10, 32'hE, 4'd3, 1'b0, 4'h0, 1'b0, 4'h0);
        idle();
    endtask

    task automatic t_down();
        access("R7 at limit", 2'd0, 4'd4, 32'hFFF, 32'hFFF, 4'd0, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R7 small ceil fit", 2'd0, 4'd4, 32'hFFF, 32'hFFFC, 4'd3, 1'b0, 4'h0, 1'b1, 4'h0);
        access("R7 small ceil over", 2'd0, 4'd4, 32'hFFF, 32'hFFFD, 4'd3, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R7 past small ceil", 2'd0, 4'd4, 32'hFFF, 32'h10000, 4'd0, 1'b0, 4'h0, 1'b0, 4'h0);
        access("R7 big ceil", 2'd0, 4'd4, 32'hFFF, 32'h10000, 4'd0, 1'b1, 4'h0, 1'b1, 4'h0);
        access("R7 big last byte", 2'd0, 4'd4, 32'hFFF, 32'hFFFF_FFFF, 4'd0, 1'b1, 4'h0, 1'b1, 4'h0);
        access("R7 big wrap", 2'd0, 4'd4, 32'hFFF, 32'hFFFF_FFFF, 4'd1, 1'b1, 4'h0, 1'b0, 4'h0);
        idle();
    endtask

    task automatic t_fast();
        access("R8 write full", 2'd1, 4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 4'd15, 1'b0, 4'h0, 1'b1, 4'hF);
        access("R8 read full", 2'd0, 4'd1, 32'hFFFF_FFFF, 32'h0, 4'd0, 1'b0, 4'h0, 1'b1, 4'h5);
        access("R8 limit seven", 2'd0, 4'd2, 32'd7, 32'd0, 4'd7, 1'b0, 4'h0, 1'b1, 4'h1);
        access("R8 limit six", 2'd0, 4'd2, 32'd6, 32'd0, 4'd0, 1'b0, 4'h0, 1'b1, 4'h0);
        idle();
    endtask

    task automatic t_sticky();
        access("R9 down full", 2'd1, 4'd7, 32'h0, 32'h8, 4'd0, 1'b1, 4'h0, 1'b1, 4'h0);
        access("R9 merge", 2'd0, 4'd2, 32'hFF, 32'h0, 4'd0, 1'b0, 4'hA, 1'b1, 4'hB);
        access("R9 keep on fault", 2'd1, 4'd8, 32'hFF, 32'h0, 4'd0, 1'b0, 4'h6, 1'b0, 4'h6);
        idle();
    endtask

    task automatic t_stack();
        seg_is_stack = 1'b1;
        access("R10 stack fault", 2'd0, 4'd2, 32'h3, 32'h8, 4'd0, 1'b0, 4'h2, 1'b0, 4'h2);
        access("R10 stack pass", 2'd1, 4'd3, 32'hFF, 32'h0, 4'd1, 1'b0, 4'h4, 1'b1, 4'h7);
        seg_is_stack = 1'b0;
        access("R10 gp fault", 2'd0, 4'd12, 32'hFF, 32'h0, 4'd0, 1'b0, 4'h0, 1'b0, 4'h0);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_long();
        t_desc();
        t_write();
        t_read();
        t_exec();
        t_up();
        t_down();
        t_fast();
        t_sticky();
        t_stack();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule